// File: doc/BRIEF.md
# I2C Slave Address Matcher with All-Call

This block sits behind the bit-level receiver of an I2C slave. When the receiver has shifted in the first byte after a START, it presents the byte with a one-cycle strobe. The matcher then decides whether the byte selects this device and registers that decision.

The device answers to two kinds of address. The first is its own address: a fixed six-bit prefix followed by the level of a board strap pin, so two devices can share one bus. The second is a shared all-call address. Several expanders with different individual addresses can all accept the same write through it at once. All-call accepts writes only, and an enable input can switch it off.

The decision carries an acknowledge bit, a flag for the address that matched, and the transfer direction. It stays valid until the receiver reports the next START or STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `ack`, `hit_ind`, `hit_all`, `is_read` and `dec_vld` are all 0.
- R2: The individual address is {`IND_PREFIX`, strap}. The strap is the level of `sel_pin` sampled while `rst_n` is low. Changes on `sel_pin` after reset is released have no effect on matching.
- R3: A byte whose upper seven bits equal the individual address gives `ack`=1 and `hit_ind`=1 for both reads (bit 0 = 1) and writes (bit 0 = 0).
- R4: With `allcall_en`=1, a write (bit 0 = 0) to `ALLCALL_ADDR` gives `ack`=1 and `hit_all`=1.
- R5: A read (bit 0 = 1) to `ALLCALL_ADDR` gives `ack`=0, `hit_all`=0 and `hit_ind`=0.
- R6: With `allcall_en`=0, `ALLCALL_ADDR` gives `ack`=0 and both flags 0, in either direction.
- R7: Any other address gives `ack`=0 and both flags 0. When `ack`=1, exactly one of `hit_ind` and `hit_all` is 1.
- R8: The decision appears on the clock edge after the edge that samples `byte_vld`=1. At that point `dec_vld`=1 and `is_read` equals bit 0 of the byte.
- R9: The decision is held unchanged until `start_det` or `stop_det` is sampled. The edge that samples either one clears all outputs to 0. The clear wins over a `byte_vld` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is sampled while low |
| sel_pin | input | 1 | Address-select strap pin |
| allcall_en | input | 1 | Enables acceptance of the all-call address |
| addr_byte | input | 8 | Received byte: [7:1] address, [0] R/W (1 = read) |
| byte_vld | input | 1 | One-cycle strobe marking a complete address byte |
| start_det | input | 1 | START condition seen on the bus |
| stop_det | input | 1 | STOP condition seen on the bus |
| ack | output | 1 | Acknowledge the address byte |
| hit_ind | output | 1 | Individual address matched and acknowledged |
| hit_all | output | 1 | All-call address matched and acknowledged |
| is_read | output | 1 | Direction of the decoded transfer |
| dec_vld | output | 1 | A decision is being held |

## Verification
Every decision is due exactly one edge after the strobe is sampled, and a START or STOP clears the outputs on the next edge. The bench drives each input on a falling edge, lets one rising edge pass, and reads the outputs on the following falling edge. Hold behaviour is checked by re-reading the outputs several falling edges later, with no strobe in between. The strap is checked across two resets with opposite pin levels, and the pin is toggled afterwards to show it is ignored.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter logic [5:0] IND_PREFIX   = 6'b010000,
  parameter logic [6:0] ALLCALL_ADDR = 7'h68
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_pin,
  input  logic       allcall_en,
  input  logic [7:0] addr_byte,
  input  logic       byte_vld,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       ack,
  output logic       hit_ind,
  output logic       hit_all,
  output logic       is_read,
  output logic       dec_vld
);

  logic       sel_q;
  logic [6:0] own_addr;
  logic       rd_bit;
  logic       m_ind;
  logic       m_all;
  logic       clr;

  assign own_addr = {IND_PREFIX, sel_q};
  assign rd_bit   = addr_byte[0];
  assign m_ind    = (addr_byte[7:1] == own_addr);
  assign m_all    = !m_ind && allcall_en && !rd_bit && (addr_byte[7:1] == ALLCALL_ADDR);
  assign clr      = start_det || stop_det;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= sel_pin;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ack     <= 1'b0;
      hit_ind <= 1'b0;
      hit_all <= 1'b0;
      is_read <= 1'b0;
      dec_vld <= 1'b0;
    end else if (byte_vld) begin
      ack     <= m_ind || m_all;
      hit_ind <= m_ind;
      hit_all <= m_all;
      is_read <= rd_bit;
      dec_vld <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_q,
  input logic byte_vld,
  input logic start_det,
  input logic stop_det,
  input logic ack,
  input logic hit_ind,
  input logic hit_all,
  input logic is_read,
  input logic dec_vld
);

  assert_idle_no_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> !ack && !hit_ind && !hit_all);

  assert_strap_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(sel_q));

  assert_one_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $countones({hit_ind, hit_all}) == 1);

  assert_allcall_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |-> !hit_all);

  assert_decision_due_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && !start_det && !stop_det |=> dec_vld);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det || stop_det |=> !dec_vld && !ack);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld && !byte_vld && !start_det && !stop_det |=>
      $stable({ack, hit_ind, hit_all, is_read, dec_vld}));

endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .byte_vld(byte_vld),
  .start_det(start_det), .stop_det(stop_det), .ack(ack),
  .hit_ind(hit_ind), .hit_all(hit_all), .is_read(is_read), .dec_vld(dec_vld)
);

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] PFX = 6'b010000;
  localparam logic [6:0] GCA = 7'h68;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_pin = 1'b0;
  logic allcall_en = 1'b0;
  logic [7:0] addr_byte = 8'h00;
  logic byte_vld = 1'b0;
  logic start_det = 1'b0;
  logic stop_det = 1'b0;
  logic ack, hit_ind, hit_all, is_read, dec_vld;

  int checks = 0;
  int fails = 0;
  logic strap;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_match #(.IND_PREFIX(PFX), .ALLCALL_ADDR(GCA)) i_i2c_addr_match (
    .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .allcall_en(allcall_en),
    .addr_byte(addr_byte), .byte_vld(byte_vld), .start_det(start_det),
    .stop_det(stop_det), .ack(ack), .hit_ind(hit_ind), .hit_all(hit_all),
    .is_read(is_read), .dec_vld(dec_vld)
  );

  function automatic logic [4:0] expect_dec(logic [7:0] b, logic s, logic en);
    logic i, a;
    i = (b[7:1] == {PFX, s});
    a = !i && en && !b[0] && (b[7:1] == GCA);
    return {i || a, i, a, b[0], 1'b1};
  endfunction

  task automatic chk(string req, logic [4:0] got, logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got {ack,ind,all,rd,vld}=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {ack, hit_ind, hit_all, is_read, dec_vld};
  endfunction

  task automatic do_reset(logic pin);
    @(negedge clk);
    rst_n = 1'b0;
    sel_pin = pin;
    repeat (3) @(negedge clk);
    chk("R1 in reset", outs(), 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", outs(), 5'b0);
    strap = pin;
  endtask

  task automatic send(logic [7:0] b, logic en, string req);
    addr_byte = b;
    allcall_en = en;
    byte_vld = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0;
    chk(req, outs(), expect_dec(b, strap, en));
  endtask

  task automatic bus_cond(logic st);
    start_det = st;
    stop_det = !st;
    @(negedge clk);
    start_det = 1'b0;
    stop_det = 1'b0;
    chk("R9 clear", outs(), 5'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [4:0] held;
    void'($urandom(32'd1234));

    do_reset(1'b1);
    send({PFX, 1'b1, 1'b0}, 1'b0, "R3 ind write strap1");
    send({PFX, 1'b1, 1'b1}, 1'b0, "R3 ind read strap1");
    send({PFX, 1'b0, 1'b0}, 1'b1, "R2 other strap addr");
    sel_pin = 1'b0;
    repeat (2) @(negedge clk);
    send({PFX, 1'b1, 1'b0}, 1'b0, "R2 pin change ignored");
    send({PFX, 1'b0, 1'b1}, 1'b0, "R2 pin change ignored 2");

    do_reset(1'b0);
    send({PFX, 1'b0, 1'b0}, 1'b0, "R3 ind write strap0");
    send({GCA, 1'b0}, 1'b1, "R4 allcall write");
    held = outs();
    repeat (4) @(negedge clk);
    chk("R9 hold", outs(), held);
    send({GCA, 1'b1}, 1'b1, "R5 allcall read");
    send({GCA, 1'b0}, 1'b0, "R6 allcall disabled write");
    send({GCA, 1'b1}, 1'b0, "R6 allcall disabled read");
    send(8'hFE, 1'b1, "R7 other address");
    send(8'h00, 1'b1, "R7 zero address");
    send({PFX, 1'b0, 1'b1}, 1'b1, "R8 is_read follows bit0");
    bus_cond(1'b1);
    send({GCA, 1'b0}, 1'b1, "R8 after clear");
    bus_cond(1'b0);

    send({PFX, 1'b0, 1'b0}, 1'b0, "R9 setup");
    start_det = 1'b1;
    byte_vld = 1'b1;
    addr_byte = {GCA, 1'b0};
    @(negedge clk);
    start_det = 1'b0;
    byte_vld = 1'b0;
    chk("R9 clear beats strobe", outs(), 5'b0);

    for (int n = 0; n < 300; n++) begin
      logic [7:0] b;
      logic en;
      case ($urandom % 4)
        0: b = {PFX, strap, 1'b0};
        1: b = {PFX, !strap, 1'b0};
        2: b = {GCA, 1'b0};
        default: b = 8'($urandom);
      endcase
      b[0] = 1'($urandom);
      en = 1'($urandom);
      send(b, en, "R7 random decision");
      if ($urandom % 3 == 0) bus_cond(1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule